// File: doc/BRIEF.md
# Programmable Chip Select with Wait-State Acknowledge

This block sits between a processor's external bus and a set of memory and peripheral devices. It compares each 24-bit bus address against eight programmable regions and drives one active-low select line for the region that matches. Each region has its own base address, block size, enable, write-protect flag and acknowledge settings. Regions 0 to 3 can cover up to 16 MB. Regions 4 to 7 are limited to 4 MB.

A bus cycle starts when the active-low address strobe is sampled low. The block then either asserts the winning select line or, for a write to a protected region, raises a one-cycle bus-error pulse and leaves all selects high. When automatic acknowledge is enabled for the winning region, the active-low transfer acknowledge follows after a programmed number of wait states. When it is disabled, external logic must supply the acknowledge. Regions are programmed through a simple write port that takes a region index, a field selector and a data word.

Top module: `bus_select_ctrl`

## Requirements
- R1: After reset, only region 0 is enabled. It has base 0, size code 15, is read-only, has automatic acknowledge on and a wait count of 6. Regions 1 to 7 are disabled.
- R2: The first rising edge with `as_n` low and an enabled region matching `addr` drives that region's `cs_n` bit low. The line then holds steady until the strobe rises. When no enabled region matches, `cs_n` stays all ones.
- R3: A region matches when `addr` and its base agree in every bit at or above position 12 + size code. That position is capped at 24 (16 MB) for regions 0 to 3 and at 22 (4 MB) for regions 4 to 7.
- R4: When several enabled regions match one address, the lowest-numbered region is selected.
- R5: At most one `cs_n` bit is low at any time.
- R6: A write (`rw` = 0) that selects a read-only region leaves `cs_n` all ones and raises `berr` for exactly one cycle, at the first edge of the cycle.
- R7: With automatic acknowledge on and wait count W, `dtack_n` goes low at the rising edge W cycles after the edge that asserted the select. A wait count of 7 behaves as 6. Once low, `dtack_n` stays low while the strobe stays low.
- R8: With automatic acknowledge off, `dtack_n` stays high for the whole cycle.
- R9: At the first rising edge with `as_n` high, `cs_n` returns to all ones and `dtack_n` returns to 1.
- R10: A write with `cfg_we` = 1 and `cfg_field` = 0 loads the control word of region `cfg_idx`. Its fields are: bit 0 enable, bit 1 read-only, bit 2 automatic acknowledge, bits 6:4 wait count, bits 11:8 size code. With `cfg_field` = 1 the write loads the base address from bits 23:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 3 | Region being programmed |
| cfg_field | input | 1 | 0 = control word, 1 = base address |
| cfg_wdata | input | 32 | Configuration write data |
| as_n | input | 1 | Active-low address strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 24 | Bus address |
| cs_n | output | 8 | Active-low select lines, one per region |
| dtack_n | output | 1 | Active-low transfer acknowledge |
| berr | output | 1 | Bus-error pulse for writes to read-only regions |

## Verification
The assertions check on every cycle the properties that hold for any configuration:
- at most one select line is low;
- select and acknowledge are released after the strobe rises;
- the bus error is a single-cycle pulse that never coincides with a select;
- an acknowledge only appears alongside a select and is held once given.

Only the bench scenarios can show the rest, because each depends on the programmed contents of the regions:
- which region wins for a given address;
- the exact size clamping for the two region groups;
- the reset map;
- the exact acknowledge delay for each wait count.

// File: rtl/csel_pkg.sv
// Package: shared constants, region configuration type and cycle states
// for the chip-select block. Assumes a 24-bit byte address.
package csel_pkg;
    localparam int ADDR_W   = 24;
    localparam int WAIT_W   = 3;
    localparam int SIZE_W   = 4;
    localparam int MAX_WAIT = 6;
    localparam int MIN_LOG  = 12;
    localparam int DATA_W   = 32;

    typedef struct packed {
        logic              en;
        logic              ro;
        logic              auto_ack;
        logic [WAIT_W-1:0] wait_cnt;
        logic [SIZE_W-1:0] size_code;
        logic [ADDR_W-1:0] base;
    } region_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HOLD   = 2'd2
    } cyc_state_t;

    // Mask of the address bits compared for a region of the given size code.
    function automatic logic [ADDR_W-1:0] cmp_mask(input logic [SIZE_W-1:0] code,
                                                   input int max_log);
        int lg;
        logic [ADDR_W-1:0] m;
        lg = MIN_LOG + int'(code);
        if (lg > max_log) lg = max_log;
        for (int i = 0; i < ADDR_W; i++) m[i] = (i >= lg);
        return m;
    endfunction
endpackage

// File: rtl/csel_cfg_regs.sv
// Region configuration bank. Holds one control word and one base address
// per region, written through a single-word write port. Assumes cfg_idx is
// below N_REG; other indices are ignored. Region 0 resets to a read-only
// boot map at address zero; all other regions reset disabled.
module csel_cfg_regs
    import csel_pkg::*;
#(
    parameter int N_REG = 8,
    parameter int IDX_W = $clog2(N_REG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic                      cfg_field,
    input  logic [DATA_W-1:0]         cfg_wdata,
    output region_cfg_t [N_REG-1:0]   cfg_o
);
    localparam logic [WAIT_W-1:0] BOOT_WAIT = WAIT_W'(MAX_WAIT);
    localparam logic [SIZE_W-1:0] BOOT_SIZE = '1;

    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        localparam logic IS_BOOT = (g == 0);
        // Purpose: reset and update the configuration of region g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[g].en        <= IS_BOOT;
                cfg_o[g].ro        <= IS_BOOT;
                cfg_o[g].auto_ack  <= IS_BOOT;
                cfg_o[g].wait_cnt  <= IS_BOOT ? BOOT_WAIT : '0;
                cfg_o[g].size_code <= IS_BOOT ? BOOT_SIZE : '0;
                cfg_o[g].base      <= '0;
            end else if (cfg_we && (int'(cfg_idx) == g)) begin
                if (!cfg_field) begin
                    cfg_o[g].en        <= cfg_wdata[0];
                    cfg_o[g].ro        <= cfg_wdata[1];
                    cfg_o[g].auto_ack  <= cfg_wdata[2];
                    cfg_o[g].wait_cnt  <= cfg_wdata[4 +: WAIT_W];
                    cfg_o[g].size_code <= cfg_wdata[8 +: SIZE_W];
                end else begin
                    cfg_o[g].base      <= cfg_wdata[ADDR_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/csel_region_match.sv
// Address comparator for one region. Compares the address with the base
// above the region's size boundary; the boundary is capped at MAX_LOG.
// Purely combinational.
module csel_region_match
    import csel_pkg::*;
#(
    parameter int MAX_LOG = 24
) (
    input  region_cfg_t       cfg_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    logic [ADDR_W-1:0] mask;

    // Purpose: build the compare mask and test the masked difference.
    always_comb begin
        mask  = cmp_mask(cfg_i.size_code, MAX_LOG);
        hit_o = cfg_i.en && (((addr_i ^ cfg_i.base) & mask) == '0);
    end
endmodule

// File: rtl/csel_priority.sv
// Fixed-priority picker: reports whether any hit is present and the index
// of the lowest-numbered hit. Purely combinational.
module csel_priority #(
    parameter int N_REG = 8,
    parameter int IDX_W = $clog2(N_REG)
) (
    input  logic [N_REG-1:0] hits_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Purpose: scan from the top so the lowest index is written last.
    always_comb begin
        any_o = |hits_i;
        idx_o = '0;
        for (int i = N_REG - 1; i >= 0; i--) begin
            if (hits_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/csel_cycle_fsm.sv
// Bus-cycle sequencer. On the first edge with the strobe low it selects the
// winning region or flags a protected write, latches the acknowledge
// settings, counts wait states, and releases everything on the first edge
// with the strobe high. Assumes the address and direction are steady while
// the strobe is low.
module csel_cycle_fsm
    import csel_pkg::*;
#(
    parameter int N_REG = 8,
    parameter int IDX_W = $clog2(N_REG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              rw,
    input  logic              any_hit,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic              win_ro,
    input  logic              win_auto,
    input  logic [WAIT_W-1:0] win_wait,
    output logic [N_REG-1:0]  cs_n,
    output logic              dtack_n,
    output logic              berr
);
    localparam logic [WAIT_W-1:0] WAIT_CAP = WAIT_W'(MAX_WAIT);
    localparam logic [WAIT_W-1:0] CNT_TOP  = '1;

    cyc_state_t        state;
    logic [WAIT_W-1:0] cnt;
    logic [WAIT_W-1:0] eff_wait;
    logic [WAIT_W-1:0] wait_q;
    logic              auto_q;

    // Purpose: clamp the requested wait count to the supported maximum.
    always_comb begin
        eff_wait = (win_wait > WAIT_CAP) ? WAIT_CAP : win_wait;
    end

    // Purpose: advance the bus-cycle state and drive the registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            wait_q  <= '0;
            auto_q  <= 1'b0;
            cs_n    <= '1;
            dtack_n <= 1'b1;
            berr    <= 1'b0;
        end else begin
            berr <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (!as_n) begin
                        if (any_hit && !(win_ro && !rw)) begin
                            cs_n          <= '1;
                            cs_n[win_idx] <= 1'b0;
                            wait_q        <= eff_wait;
                            auto_q        <= win_auto;
                            cnt           <= WAIT_W'(1);
                            dtack_n       <= !(win_auto && (eff_wait == '0));
                            state         <= ST_ACTIVE;
                        end else begin
                            berr  <= any_hit;
                            state <= ST_HOLD;
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (as_n) begin
                        cs_n    <= '1;
                        dtack_n <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        if (auto_q && (cnt >= wait_q)) dtack_n <= 1'b0;
                        if (cnt != CNT_TOP) cnt <= cnt + WAIT_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (as_n) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bus_select_ctrl.sv
// Top of the programmable chip-select block. Holds the region bank,
// compares the bus address against every region in parallel, picks the
// lowest matching region and runs the bus-cycle sequencer. The first
// BIG_REGIONS regions may span up to 2^BIG_MAX_LOG bytes; the rest are
// capped at 2^SMALL_MAX_LOG bytes.
module bus_select_ctrl
    import csel_pkg::*;
#(
    parameter int N_REG         = 8,
    parameter int BIG_REGIONS   = 4,
    parameter int BIG_MAX_LOG   = 24,
    parameter int SMALL_MAX_LOG = 22,
    localparam int IDX_W        = $clog2(N_REG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_field,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              as_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_REG-1:0]  cs_n,
    output logic              dtack_n,
    output logic              berr
);
    region_cfg_t [N_REG-1:0] cfg;
    logic [N_REG-1:0]        hits;
    logic                    any_hit;
    logic [IDX_W-1:0]        win_idx;
    region_cfg_t             win_cfg;

    csel_cfg_regs #(.N_REG(N_REG), .IDX_W(IDX_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_field (cfg_field),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg)
    );

    for (genvar g = 0; g < N_REG; g++) begin : g_match
        localparam int LIM = (g < BIG_REGIONS) ? BIG_MAX_LOG : SMALL_MAX_LOG;
        csel_region_match #(.MAX_LOG(LIM)) match_i (
            .cfg_i  (cfg[g]),
            .addr_i (addr),
            .hit_o  (hits[g])
        );
    end

    csel_priority #(.N_REG(N_REG), .IDX_W(IDX_W)) prio_i (
        .hits_i (hits),
        .any_o  (any_hit),
        .idx_o  (win_idx)
    );

    // Purpose: route the winning region's settings to the sequencer.
    always_comb begin
        win_cfg = cfg[win_idx];
    end

    csel_cycle_fsm #(.N_REG(N_REG), .IDX_W(IDX_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .as_n     (as_n),
        .rw       (rw),
        .any_hit  (any_hit),
        .win_idx  (win_idx),
        .win_ro   (win_cfg.ro),
        .win_auto (win_cfg.auto_ack),
        .win_wait (win_cfg.wait_cnt),
        .cs_n     (cs_n),
        .dtack_n  (dtack_n),
        .berr     (berr)
    );
endmodule

// File: rtl/bus_select_ctrl_chk.sv
// Checker for bus_select_ctrl: port-level temporal properties, bound to
// every instance of the top module.
module bus_select_ctrl_chk #(
    parameter int N_REG = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             as_n,
    input logic [N_REG-1:0] cs_n,
    input logic             dtack_n,
    input logic             berr
);
    assert_single_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> ((&cs_n) && dtack_n));

    assert_berr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        berr |=> !berr);

    assert_berr_no_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        berr |-> (&cs_n));

    assert_dtack_with_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> !(&cs_n));

    assert_dtack_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && !as_n) |=> !dtack_n);

    assert_cs_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !as_n) |=> $stable(cs_n));
endmodule

bind bus_select_ctrl bus_select_ctrl_chk #(.N_REG(N_REG)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .as_n    (as_n),
    .cs_n    (cs_n),
    .dtack_n (dtack_n),
    .berr    (berr)
);

// File: tb/bus_select_ctrl_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random cycles,
// compared against a behavioural model of the region map.
module bus_select_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_field = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        as_n = 1'b1;
    logic        rw = 1'b1;
    logic [23:0] addr = '0;
    logic [7:0]  cs_n;
    logic        dtack_n;
    logic        berr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    bit          m_en[8];
    bit          m_ro[8];
    bit          m_auto[8];
    int          m_wait[8];
    int          m_size[8];
    logic [23:0] m_base[8];

    always #10 clk = ~clk;

    bus_select_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .as_n(as_n), .rw(rw),
        .addr(addr), .cs_n(cs_n), .dtack_n(dtack_n), .berr(berr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit model_hit(input int r, input logic [23:0] a);
        int lg;
        int lim;
        logic [23:0] m;
        lim = (r < 4) ? 24 : 22;
        lg = 12 + m_size[r];
        if (lg > lim) lg = lim;
        for (int i = 0; i < 24; i++) m[i] = (i >= lg);
        return m_en[r] && (((a ^ m_base[r]) & m) == 24'h0);
    endfunction

    function automatic int model_winner(input logic [23:0] a);
        for (int r = 0; r < 8; r++) if (model_hit(r, a)) return r;
        return -1;
    endfunction

    task automatic wr_ctrl(input int r, input bit en, input bit ro, input bit au,
                           input int w, input int sz);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(r); cfg_field = 1'b0;
        cfg_wdata = {20'h0, 4'(sz), 1'b0, 3'(w), 1'b0, au, ro, en};
        @(negedge clk);
        cfg_we = 1'b0;
        m_en[r] = en; m_ro[r] = ro; m_auto[r] = au; m_wait[r] = w; m_size[r] = sz;
    endtask

    task automatic wr_base(input int r, input logic [23:0] b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(r); cfg_field = 1'b1; cfg_wdata = {8'hA5, b};
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[r] = b;
    endtask

    // One bus cycle: check select/berr at first edge, acknowledge timing, release.
    task automatic bus_cycle(input logic [23:0] a, input bit rd, input string tag);
        int win;
        bit blocked;
        int exp_ack;
        int first_ack;
        logic [7:0] exp_cs;
        win = model_winner(a);
        blocked = (win >= 0) && m_ro[win] && !rd;
        exp_cs = (win >= 0 && !blocked) ? ~(8'h1 << win) : 8'hFF;
        exp_ack = -1;
        if (win >= 0 && !blocked && m_auto[win]) exp_ack = (m_wait[win] > 6) ? 6 : m_wait[win];
        first_ack = -1;
        @(negedge clk);
        as_n = 1'b0; addr = a; rw = rd;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            check(cs_n == exp_cs, {tag, " R2 cs_n"}, int'(cs_n), int'(exp_cs));
            if (k == 0) check(berr == blocked, {tag, " R6 berr"}, int'(berr), int'(blocked));
            if (k == 1) check(berr == 1'b0, {tag, " R6 berr pulse"}, int'(berr), 0);
            if (!dtack_n && first_ack < 0) first_ack = k;
        end
        check(first_ack == exp_ack, {tag, " R7 R8 ack edge"}, first_ack, exp_ack);
        as_n = 1'b1;
        @(negedge clk);
        check(cs_n == 8'hFF && dtack_n == 1'b1, {tag, " R9 release"},
              int'({cs_n, dtack_n}), 9'h1FF);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int r;
        logic [23:0] a;
        void'($urandom(32'd2718));
        for (int i = 0; i < 8; i++) begin
            m_en[i] = (i == 0); m_ro[i] = (i == 0); m_auto[i] = (i == 0);
            m_wait[i] = (i == 0) ? 6 : 0; m_size[i] = (i == 0) ? 15 : 0; m_base[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 8'hFF && dtack_n && !berr, "R1 idle outputs", int'(cs_n), 8'hFF);
        // R1: boot map covers whole space, read-only, wait 6
        bus_cycle(24'h123456, 1'b1, "R1 boot read");
        bus_cycle(24'hFFFFFE, 1'b0, "R1 boot write");
        // R10 R3: region 4 with oversized code clamps to 4 MB
        wr_ctrl(0, 0, 0, 0, 0, 0);
        wr_base(4, 24'h400000);
        wr_ctrl(4, 1, 0, 1, 2, 15);
        bus_cycle(24'h7FFFFF, 1'b0, "R3 top of 4MB");
        bus_cycle(24'h800000, 1'b1, "R3 outside 4MB");
        bus_cycle(24'h3FFFFF, 1'b1, "R3 below base");
        // R3: 4 KB region edge
        wr_base(5, 24'h012000);
        wr_ctrl(5, 1, 0, 1, 0, 0);
        bus_cycle(24'h012FFF, 1'b1, "R3 4KB end");
        bus_cycle(24'h013000, 1'b1, "R3 4KB past");
        // R4: overlapping regions 1 and 2, lower wins
        wr_base(2, 24'h000000);
        wr_ctrl(2, 1, 0, 1, 1, 12);
        wr_base(1, 24'h012000);
        wr_ctrl(1, 1, 0, 1, 3, 1);
        bus_cycle(24'h012010, 1'b1, "R4 overlap");
        // R8: no automatic acknowledge
        wr_ctrl(1, 1, 0, 0, 3, 1);
        bus_cycle(24'h012010, 1'b0, "R8 ext ack");
        // R7: wait 0 and wait 7 (clamped)
        wr_ctrl(1, 1, 0, 1, 0, 1);
        bus_cycle(24'h012010, 1'b1, "R7 wait0");
        wr_ctrl(1, 1, 0, 1, 7, 1);
        bus_cycle(24'h012010, 1'b1, "R7 wait7");
        // R6: read-only region passes reads
        wr_ctrl(1, 1, 1, 1, 2, 1);
        bus_cycle(24'h012010, 1'b1, "R6 ro read");
        bus_cycle(24'h012010, 1'b0, "R6 ro write");
        // random mix
        for (int it = 0; it < 200; it++) begin
            if ($urandom_range(0, 2) == 0) begin
                r = $urandom_range(0, 7);
                wr_base(r, 24'($urandom()));
                wr_ctrl(r, 1'($urandom()), 1'($urandom()), 1'($urandom()),
                        $urandom_range(0, 7), $urandom_range(0, 15));
            end
            r = $urandom_range(0, 7);
            a = ($urandom_range(0, 3) == 0) ? 24'($urandom())
                                             : (m_base[r] ^ 24'($urandom_range(0, 16'hFFFF)));
            bus_cycle(a, 1'($urandom()), "R2 R4 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule